// File: doc/BRIEF.md
# DRAM Bank State and Timing Tracker

This block follows a stream of synchronous DRAM commands and keeps a record of every bank. For each bank it records whether the bank is idle or holds an open row, and which row that is. Each cycle it judges the command on its inputs against that record and against the minimum spacings a DRAM device requires. It raises a legal flag or an illegal flag in the same cycle.

A legal command takes effect on the next clock edge. An illegal one is dropped, and no bank state or timing window changes because of it. The block is a checker and recorder for a memory controller's command path. It does not drive DRAM pins, move data or choose when to refresh.

Every spacing is a parameter counted in clock cycles. Each bank runs three countdown windows: open-to-access, open-to-close, and close-to-open. The activate-to-activate spacing is shared by all banks.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is idle, every reported row is zero, and a NOP on the inputs raises neither flag.
- R2: An activate (code 1) to an idle bank opens it with the given row, and the row appears on that bank's field of the row output after the next edge. An activate to a bank that is already open is illegal.
- R3: A read (code 2) or write (code 3) is illegal to an idle bank. It is also illegal until T_RCD cycles have passed since that bank's activate; at exactly T_RCD cycles it is legal.
- R4: An activate is illegal until T_RRD cycles have passed since the previous legal activate to any bank.
- R5: A precharge (code 4) to an open bank is illegal until T_RAS cycles after its activate. Once legal it closes the bank. A precharge to an idle bank is legal and changes nothing.
- R6: After a precharge, the next activate to that bank is illegal until T_RP cycles have passed. It is also illegal until T_RAS+T_RP cycles have passed since the bank's previous activate.
- R7: A precharge is illegal until T_RTP cycles after a read to the bank. After a write it is illegal until T_WL+T_BURST+T_WR cycles have passed.
- R8: A read (code 6) or write (code 7) with auto-precharge obeys the read and write rules and leaves the bank idle after the edge. The bank's next activate is legal only once the implied precharge point and T_RP have both elapsed.
- R9: Precharge-all (code 5) ignores the bank input. It is legal only when every open bank is past its precharge window, and it then closes all banks.
- R10: Refresh (code 8) is legal only when every bank is idle and past its close-to-open window. After a refresh, no activate is legal until T_RFC cycles have passed.
- R11: An illegal command changes no bank's open state or row.
- R12: legal_o is high for a legal command other than NOP (code 0). illegal_o is high for an illegal command. Codes 9 to 15 are always illegal, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 4 | Command code for this cycle |
| bank_i | input | $clog2(NUM_BANKS) | Target bank |
| row_i | input | ROW_W | Row address used by activate |
| legal_o | output | 1 | Command accepted (combinational) |
| illegal_o | output | 1 | Command refused (combinational) |
| bank_active_o | output | NUM_BANKS | One bit per bank, high when a row is open |
| open_row_o | output | NUM_BANKS*ROW_W | Row of each bank, bank 0 in the low bits |

## Verification
The hardest situations to reach are those where two windows overlap on one bank. Examples are the implied precharge inside a read or write with auto-precharge, and a refresh that is blocked only because a just-closed bank is still inside its close-to-open window. Each directed scenario starts from reset and places the commands on exact cycle offsets from an activate. The offsets are chosen so that the boundary cycle of the dominant window falls one cycle apart from the others. The command one cycle before each boundary is expected to be refused, and the command on the boundary cycle is expected to be accepted.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    // Command codes seen on cmd_i
    localparam logic [3:0] CMD_NOP  = 4'd0;
    localparam logic [3:0] CMD_ACT  = 4'd1;
    localparam logic [3:0] CMD_RD   = 4'd2;
    localparam logic [3:0] CMD_WR   = 4'd3;
    localparam logic [3:0] CMD_PRE  = 4'd4;
    localparam logic [3:0] CMD_PREA = 4'd5;
    localparam logic [3:0] CMD_RDA  = 4'd6;
    localparam logic [3:0] CMD_WRA  = 4'd7;
    localparam logic [3:0] CMD_REF  = 4'd8;

    // Operation handed to one bank after the verdict
    typedef enum logic [2:0] {
        BOP_NONE,
        BOP_ACT,
        BOP_RD,
        BOP_WR,
        BOP_PRE,
        BOP_RDA,
        BOP_WRA,
        BOP_REF
    } bank_op_e;

endpackage

// File: rtl/dbt_bank.sv
module dbt_bank
    import dbt_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int CNT_W   = 6,
    parameter int T_RCD   = 3,
    parameter int T_RAS   = 5,
    parameter int T_RP    = 3,
    parameter int T_RTP   = 2,
    parameter int T_WRPRE = 6,
    parameter int T_RFC   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_op_e         op_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rw_ready_o,
    output logic             pre_ready_o,
    output logic             act_ready_o
);

    localparam int T_RC = T_RAS + T_RP;
    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] L_RTP = CNT_W'(T_RTP - 1);
    localparam logic [CNT_W-1:0] L_WRP = CNT_W'(T_WRPRE - 1);
    localparam logic [CNT_W-1:0] L_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] K_RP  = CNT_W'(T_RP);

    typedef struct packed {
        logic             active;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] to_rw;   // open -> access window
        logic [CNT_W-1:0] to_pre;  // open/access -> close window
        logic [CNT_W-1:0] to_act;  // close/refresh -> open window
    } bank_st_t;

    bank_st_t st_q, st_d;
    logic [CNT_W-1:0] close_at;

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [CNT_W-1:0] mx(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.to_rw  = dec(st_q.to_rw);
        st_d.to_pre = dec(st_q.to_pre);
        st_d.to_act = dec(st_q.to_act);
        close_at    = '0;
        unique case (op_i)
            BOP_ACT: begin
                st_d.active = 1'b1;
                st_d.row    = row_i;
                st_d.to_rw  = L_RCD;
                st_d.to_pre = mx(st_d.to_pre, L_RAS);
                st_d.to_act = mx(st_d.to_act, L_RC);
            end
            BOP_RD: st_d.to_pre = mx(st_d.to_pre, L_RTP);
            BOP_WR: st_d.to_pre = mx(st_d.to_pre, L_WRP);
            BOP_PRE: begin
                st_d.active = 1'b0;
                st_d.to_act = mx(st_d.to_act, L_RP);
            end
            BOP_RDA, BOP_WRA: begin
                close_at    = mx(st_d.to_pre, (op_i == BOP_RDA) ? L_RTP : L_WRP);
                st_d.active = 1'b0;
                st_d.to_pre = close_at;
                st_d.to_act = mx(st_d.to_act, close_at + K_RP);
            end
            BOP_REF: st_d.to_act = mx(st_d.to_act, L_RFC);
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o    = st_q.active;
    assign row_o       = st_q.row;
    assign rw_ready_o  = (st_q.to_rw == '0);
    assign pre_ready_o = (st_q.to_pre == '0);
    assign act_ready_o = (st_q.to_act == '0);

    AST_ACCESS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {BOP_RD, BOP_WR, BOP_RDA, BOP_WRA}) |-> (st_q.active && st_q.to_rw == '0)); // R3
    AST_OPEN_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BOP_ACT) |-> (!st_q.active && st_q.to_act == '0)); // R6
    AST_CLOSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BOP_PRE) |-> (st_q.to_pre == '0)); // R5
    AST_AUTO_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {BOP_RDA, BOP_WRA}) |=> !st_q.active); // R8

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int T_RCD     = 3,
    parameter int T_RRD     = 3,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3,
    parameter int T_RTP     = 2,
    parameter int T_WL      = 2,
    parameter int T_BURST   = 2,
    parameter int T_WR      = 2,
    parameter int T_RFC     = 6,
    localparam int NB_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [3:0]                 cmd_i,
    input  logic [NB_W-1:0]            bank_i,
    input  logic [ROW_W-1:0]           row_i,
    output logic                       legal_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_active_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);

    localparam int T_WRPRE = T_WL + T_BURST + T_WR;
    localparam int SPAN    = T_RAS + T_RP + T_RTP + T_WRPRE + T_RFC + T_RRD + T_RCD + 2;
    localparam int CNT_W   = $clog2(SPAN);
    localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] rrd;
    } top_st_t;

    top_st_t st_q, st_d;

    bank_op_e           ops       [NUM_BANKS];
    logic [NUM_BANKS-1:0] act_w, rw_rdy, pre_rdy, act_rdy;
    logic               ok, all_closable, all_quiet;

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_bank
            dbt_bank #(
                .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
                .T_RP(T_RP), .T_RTP(T_RTP), .T_WRPRE(T_WRPRE), .T_RFC(T_RFC)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .op_i(ops[g]), .row_i(row_i),
                .active_o(act_w[g]), .row_o(open_row_o[g*ROW_W +: ROW_W]),
                .rw_ready_o(rw_rdy[g]), .pre_ready_o(pre_rdy[g]), .act_ready_o(act_rdy[g])
            );
        end
    endgenerate

    // Verdict on the command present this cycle
    always_comb begin
        all_closable = 1'b1;
        all_quiet    = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (act_w[b] && !pre_rdy[b]) all_closable = 1'b0;
            if (act_w[b] || !act_rdy[b]) all_quiet    = 1'b0;
        end
        unique case (cmd_i)
            CMD_NOP:                         ok = 1'b1;
            CMD_ACT:                         ok = !act_w[bank_i] && act_rdy[bank_i] && (st_q.rrd == '0);
            CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: ok = act_w[bank_i] && rw_rdy[bank_i];
            CMD_PRE:                         ok = !act_w[bank_i] || pre_rdy[bank_i];
            CMD_PREA:                        ok = all_closable;
            CMD_REF:                         ok = all_quiet;
            default:                         ok = 1'b0;
        endcase
    end

    // Fan the accepted command out to the banks
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            ops[b] = BOP_NONE;
            if (ok) begin
                unique case (cmd_i)
                    CMD_ACT:  if (NB_W'(b) == bank_i) ops[b] = BOP_ACT;
                    CMD_RD:   if (NB_W'(b) == bank_i) ops[b] = BOP_RD;
                    CMD_WR:   if (NB_W'(b) == bank_i) ops[b] = BOP_WR;
                    CMD_RDA:  if (NB_W'(b) == bank_i) ops[b] = BOP_RDA;
                    CMD_WRA:  if (NB_W'(b) == bank_i) ops[b] = BOP_WRA;
                    CMD_PRE:  if (NB_W'(b) == bank_i && act_w[b]) ops[b] = BOP_PRE;
                    CMD_PREA: if (act_w[b]) ops[b] = BOP_PRE;
                    CMD_REF:  ops[b] = BOP_REF;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.rrd = (st_q.rrd == '0) ? '0 : st_q.rrd - 1'b1;
        if (ok && cmd_i == CMD_ACT) st_d.rrd = L_RRD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign legal_o       = ok && (cmd_i != CMD_NOP);
    assign illegal_o     = !ok;
    assign bank_active_o = act_w;

    // Independent count of cycles since the last accepted activate
    logic [CNT_W-1:0] since_act_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            since_act_q <= CNT_W'(T_RRD);
        else if (legal_o && cmd_i == CMD_ACT)  since_act_q <= CNT_W'(1);
        else if (since_act_q < CNT_W'(T_RRD))  since_act_q <= since_act_q + 1'b1;
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(legal_o && illegal_o)); // R12
    AST_REFUSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> ($stable(bank_active_o) && $stable(open_row_o))); // R11
    AST_REFRESH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_o && cmd_i == CMD_REF) |-> (bank_active_o == '0)); // R10
    AST_CLOSE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_o && cmd_i == CMD_PREA) |=> (bank_active_o == '0)); // R9
    AST_OPEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_o && cmd_i == CMD_ACT) |=> bank_active_o[$past(bank_i)]); // R2
    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_o && cmd_i == CMD_ACT) |-> (since_act_q >= CNT_W'(T_RRD))); // R4

endmodule

// File: tb/sim_dram_bank_tracker.sv
module sim_dram_bank_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int RW = 13;

    localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd3,
                           C_PRE = 4'd4, C_PREA = 4'd5, C_RDA = 4'd6, C_WRA = 4'd7,
                           C_REF = 4'd8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cmd = 4'd0;
    logic [1:0]    bank = 2'd0;
    logic [RW-1:0] row = '0;
    logic          legal, illegal;
    logic [NB-1:0] active;
    logic [NB*RW-1:0] rows;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_bank_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .row_i(row),
        .legal_o(legal), .illegal_o(illegal), .bank_active_o(active), .open_row_o(rows)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd = C_NOP; bank = '0; row = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One command in one cycle; flags checked before the edge that applies it
    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [RW-1:0] r,
                         input bit exp_ok, input string tag);
        @(negedge clk);
        cmd = c; bank = b; row = r;
        #1;
        n_checks++;
        if (legal !== (exp_ok && c != C_NOP) || illegal !== !exp_ok) begin
            n_errors++;
            $display("FAIL %s: legal=%0b illegal=%0b expected legal=%0b illegal=%0b",
                     tag, legal, illegal, exp_ok && c != C_NOP, !exp_ok);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd = C_NOP;
        end
    endtask

    // Sample state just after the edge that applied the last command
    task automatic chk_state(input logic [NB-1:0] exp_mask, input bit do_row,
                             input int b, input logic [RW-1:0] exp_row, input string tag);
        @(posedge clk);
        #1;
        n_checks++;
        if (active !== exp_mask || (do_row && rows[b*RW +: RW] !== exp_row)) begin
            n_errors++;
            $display("FAIL %s: active=%b row=%h expected active=%b row=%h",
                     tag, active, rows[b*RW +: RW], exp_mask, exp_row);
        end
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        n_checks++;
        if (active !== '0 || rows !== '0) begin
            n_errors++;
            $display("FAIL R1: active=%b rows=%h expected active=0 rows=0", active, rows);
        end
        issue(C_NOP, 2'd0, '0, 1'b1, "R1 nop after reset");
    endtask

    task automatic t_open_access();
        do_reset();
        issue(C_RD,  2'd0, '0,     1'b0, "R3 read to idle bank");
        issue(C_ACT, 2'd0, 13'h55, 1'b1, "R2 activate idle bank");
        chk_state(4'b0001, 1'b1, 0, 13'h55, "R2 row recorded");
        issue(C_RD,  2'd0, '0, 1'b0, "R3 read at tRCD-2");
        issue(C_RD,  2'd0, '0, 1'b0, "R3 read at tRCD-1");
        issue(C_RD,  2'd0, '0, 1'b1, "R3 read at tRCD");
        issue(C_ACT, 2'd0, 13'h12, 1'b0, "R2 activate open bank");
        chk_state(4'b0001, 1'b1, 0, 13'h55, "R11 row kept after refusal");
    endtask

    task automatic t_rrd();
        do_reset();
        issue(C_ACT, 2'd1, 13'h1, 1'b1, "R4 first activate");
        issue(C_ACT, 2'd2, 13'h2, 1'b0, "R4 activate at +1");
        issue(C_ACT, 2'd2, 13'h2, 1'b0, "R4 activate at +2");
        issue(C_ACT, 2'd2, 13'h2, 1'b1, "R4 activate at tRRD");
        chk_state(4'b0110, 1'b1, 2, 13'h2, "R4 both banks open");
    endtask

    task automatic t_ras_rp();
        do_reset();
        issue(C_ACT, 2'd0, 13'h7, 1'b1, "R5 activate");
        idle(3);
        issue(C_PRE, 2'd0, '0, 1'b0, "R5 precharge at tRAS-1");
        issue(C_PRE, 2'd0, '0, 1'b1, "R5 precharge at tRAS");
        chk_state(4'b0000, 1'b0, 0, '0, "R5 bank closed");
        issue(C_PRE, 2'd2, '0, 1'b1, "R5 precharge idle bank");
        chk_state(4'b0000, 1'b0, 0, '0, "R5 idle precharge no change");
        issue(C_ACT, 2'd0, 13'h8, 1'b0, "R6 activate at tRP-1");
        issue(C_ACT, 2'd0, 13'h8, 1'b1, "R6 activate at tRP");
    endtask

    task automatic t_rtp_wr();
        do_reset();
        issue(C_ACT, 2'd0, 13'h3, 1'b1, "R7 activate");
        idle(5);
        issue(C_RD,  2'd0, '0, 1'b1, "R7 late read");
        issue(C_PRE, 2'd0, '0, 1'b0, "R7 precharge at tRTP-1");
        issue(C_PRE, 2'd0, '0, 1'b1, "R7 precharge at tRTP");
        do_reset();
        issue(C_ACT, 2'd0, 13'h3, 1'b1, "R7 activate");
        idle(2);
        issue(C_WR,  2'd0, '0, 1'b1, "R7 write");
        idle(4);
        issue(C_PRE, 2'd0, '0, 1'b0, "R7 precharge one before write recovery");
        issue(C_PRE, 2'd0, '0, 1'b1, "R7 precharge after write recovery");
    endtask

    task automatic t_autopre();
        do_reset();
        issue(C_ACT, 2'd0, 13'h9, 1'b1, "R8 activate");
        idle(5);
        issue(C_RDA, 2'd0, '0, 1'b1, "R8 read with auto-precharge");
        chk_state(4'b0000, 1'b0, 0, '0, "R8 bank idle after auto read");
        issue(C_RD,  2'd0, '0, 1'b0, "R8 read after auto close");
        idle(2);
        issue(C_ACT, 2'd0, 13'h9, 1'b0, "R8 activate before implied close + tRP");
        issue(C_ACT, 2'd0, 13'h9, 1'b1, "R8 activate at implied close + tRP");
        do_reset();
        issue(C_ACT, 2'd1, 13'h4, 1'b1, "R8 activate");
        idle(2);
        issue(C_WRA, 2'd1, '0, 1'b1, "R8 write with auto-precharge");
        idle(7);
        issue(C_ACT, 2'd1, 13'h4, 1'b0, "R8 activate one early after auto write");
        issue(C_ACT, 2'd1, 13'h4, 1'b1, "R8 activate after auto write");
    endtask

    task automatic t_prea();
        do_reset();
        issue(C_ACT,  2'd0, 13'h1, 1'b1, "R9 activate bank 0");
        idle(2);
        issue(C_ACT,  2'd1, 13'h2, 1'b1, "R9 activate bank 1");
        idle(3);
        issue(C_PREA, 2'd3, '0, 1'b0, "R9 precharge-all with bank 1 inside tRAS");
        issue(C_PREA, 2'd3, '0, 1'b1, "R9 precharge-all allowed");
        chk_state(4'b0000, 1'b0, 0, '0, "R9 all banks closed");
    endtask

    task automatic t_refresh();
        do_reset();
        issue(C_ACT, 2'd0, 13'h5, 1'b1, "R10 activate");
        issue(C_REF, 2'd0, '0, 1'b0, "R10 refresh with open bank");
        idle(3);
        issue(C_PRE, 2'd0, '0, 1'b1, "R10 precharge");
        issue(C_REF, 2'd0, '0, 1'b0, "R10 refresh inside tRP");
        idle(1);
        issue(C_REF, 2'd0, '0, 1'b1, "R10 refresh allowed");
        idle(4);
        issue(C_ACT, 2'd1, 13'h6, 1'b0, "R10 activate at tRFC-1");
        issue(C_ACT, 2'd1, 13'h6, 1'b1, "R10 activate at tRFC");
    endtask

    task automatic t_codes();
        do_reset();
        issue(4'hF,  2'd0, 13'h1F, 1'b0, "R12 undefined code");
        chk_state(4'b0000, 1'b1, 0, '0, "R11 undefined code no change");
        issue(4'h9,  2'd2, '0,     1'b0, "R12 code 9");
        issue(C_NOP, 2'd0, '0,     1'b1, "R12 nop raises no flag");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_open_access();
        t_rrd();
        t_ras_rp();
        t_rtp_wr();
        t_autopre();
        t_prea();
        t_refresh();
        t_codes();
        @(negedge clk);
        cmd = C_NOP;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule